// File: doc/BRIEF.md
# Write-Protected Nonvolatile SRAM Emulator

This block is a clock-sampled, synthesizable stand-in for an 8192-by-8 battery-backed static RAM. It serves as a bus target in simulation or on an FPGA. A host drives a 13-bit address, three active-low strobes (chip select, write strobe and output gate) and a data byte. The host also supplies a digital code that stands for the monitored supply voltage. The block returns a read byte with a drive flag, since a real tri-state bus is shown here as data plus an enable. Two status flags report whether the array is write-locked and whether it is running in retention mode.

The strobes are sampled on the clock, and edges are found by comparing each sample with the one before. A write is taken while chip select and write strobe are both low, and it lands in the array when that overlap ends. The address and byte of the last overlapped sample are used. The supply code drives a three-state monitor. With a healthy supply the array works normally. When the supply sags below the lock level, every strobe is ignored, the outputs float and any write in flight is dropped. Below the retention level the block reports backup mode. It keeps the whole array and leaves the locked states only after the supply climbs past the full-operation level.

Top module: `nvsram_emu`

## Requirements
- R1: After reset the data output is not driven (`dOutEn`=0, `dOut`=0), `protFlag`=1 and `backupFlag`=0.
- R2: With `weN`=1 and `ceN`=`oeN`=0 held, the byte stored at `addr` appears on `dOut` with `dOutEn`=1 two clock edges after the inputs are applied.
- R3: A write takes place while `ceN`=0 and `weN`=0. The byte and address of the last clock sample in that overlap are stored once either strobe has been sampled high, whichever of the two rises first. This holds whichever strobe falls first.
- R4: `dOutEn` is 0 whenever `weN` is low, even with `ceN` and `oeN` both low, and also whenever `ceN` or `oeN` is high. While `dOutEn` is 0, `dOut` reads 0.
- R5: The supply code is an unsigned number. It is compared against `LVL_FULL` (default 180), `LVL_PROT` (default 170) and `LVL_BACKUP` (default 120). From normal operation, a code below `LVL_PROT` locks the array. `protFlag` then reads 1, reads return no data and writes change nothing.
- R6: A code below `LVL_BACKUP` sets `backupFlag`=1 with `protFlag`=1. A code at or above `LVL_BACKUP` clears `backupFlag`, but `protFlag` stays 1 until the code exceeds `LVL_FULL`. Array contents survive both modes.
- R7: In normal operation, a code between `LVL_PROT` and `LVL_FULL` inclusive keeps the block operating (hysteresis).
- R8: A write overlap that is still open when the lock engages is discarded, and the addressed byte keeps its old value.
- R9: All 8192 addresses are independent, and any address accepts any number of successive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 13 | Byte address |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output gate, active low |
| dIn | input | 8 | Write byte |
| supLvl | input | 8 | Supply level code |
| dOut | output | 8 | Read byte, 0 when not driven |
| dOutEn | output | 1 | Read byte is being driven |
| protFlag | output | 1 | Array is write-locked (lock or retention mode) |
| backupFlag | output | 1 | Retention mode |

## Verification
The bench builds the block with its default 13-bit address and threshold codes 180/170/120. This puts the full address space within reach of random traffic, and each threshold can be hit exactly and missed by one code. Directed steps walk the supply monitor through every transition:
- a sag into the hysteresis band,
- a drop to lock,
- a drop to retention,
- a rise that must stop at lock,
- the final recovery.

A write is also aborted by a sag that lands in the middle of its overlap.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [1:0] {
    SUP_NORMAL = 2'd0,
    SUP_LOCK   = 2'd1,
    SUP_RETAIN = 2'd2
  } supState_t;

  typedef struct packed {
    logic capture;  // overlap sample: latch address and byte
    logic commit;   // overlap ended: store latched byte
    logic rdEn;     // read conditions met this sample
  } strobe_t;

endpackage

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int SUP_W      = 8,
  parameter int LVL_FULL   = 180,
  parameter int LVL_PROT   = 170,
  parameter int LVL_BACKUP = 120
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [SUP_W-1:0] supLvl,
  output strobe_t          stb,
  output logic             protFlag,
  output logic             backupFlag
);

  localparam logic [SUP_W-1:0] FullCode = SUP_W'(LVL_FULL);
  localparam logic [SUP_W-1:0] ProtCode = SUP_W'(LVL_PROT);
  localparam logic [SUP_W-1:0] BackCode = SUP_W'(LVL_BACKUP);

  supState_t stateQ, stateD;
  logic ceQ, weQ, oeQ;
  logic armedQ;
  logic overlap, normal;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SUP_NORMAL: begin
        if (supLvl < BackCode)      stateD = SUP_RETAIN;
        else if (supLvl < ProtCode) stateD = SUP_LOCK;
      end
      SUP_LOCK: begin
        if (supLvl < BackCode)      stateD = SUP_RETAIN;
        else if (supLvl > FullCode) stateD = SUP_NORMAL;
      end
      SUP_RETAIN: begin
        if (supLvl >= BackCode)     stateD = SUP_LOCK;
      end
      default: stateD = SUP_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SUP_LOCK;
      ceQ    <= 1'b1;
      weQ    <= 1'b1;
      oeQ    <= 1'b1;
      armedQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      ceQ    <= ceN;
      weQ    <= weN;
      oeQ    <= oeN;
      armedQ <= stb.capture;
    end
  end

  assign normal      = (stateQ == SUP_NORMAL);
  assign overlap     = !ceQ && !weQ;
  assign stb.capture = normal && overlap;
  assign stb.commit  = normal && armedQ && !overlap;
  assign stb.rdEn    = normal && !ceQ && !oeQ && weQ;
  assign protFlag    = !normal;
  assign backupFlag  = (stateQ == SUP_RETAIN);

  // Retention mode never jumps straight back to normal operation.
  p_retain_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SUP_RETAIN) |=> (stateQ != SUP_NORMAL));

  // A commit only follows an overlap that has just closed.
  p_commit_after_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> ($past(overlap) && !overlap));

  // Locked states issue no array access.
  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    protFlag |-> !(stb.commit || stb.rdEn || stb.capture));

  // A lock arriving during an overlap prevents its commit.
  p_abort_on_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) != SUP_NORMAL) |-> !stb.commit);

endmodule

// File: rtl/nvsram_dp.sv
module nvsram_dp
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic [ADDR_W-1:0] addrQ, wrAddr;
  logic [DATA_W-1:0] dQ, wrData, rdData;
  logic              outEnQ;

  always_ff @(posedge clk) begin
    addrQ <= addr;
    dQ    <= dIn;
    if (stb.capture) begin
      wrAddr <= addrQ;
      wrData <= dQ;
    end
    if (stb.commit) mem[wrAddr] <= wrData;
    if (stb.rdEn)   rdData <= mem[addrQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) outEnQ <= 1'b0;
    else       outEnQ <= stb.rdEn;
  end

  assign dOutEn = outEnQ;
  assign dOut   = outEnQ ? rdData : '0;

  // The committed byte is visible in the array one edge later.
  p_commit_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (mem[$past(wrAddr)] == $past(wrData)));

  // An undriven output reads zero.
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dOutEn |-> (dOut == '0));

  // Driving follows a read request from the previous sample.
  p_drive_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    dOutEn |-> $past(stb.rdEn));

endmodule

// File: rtl/nvsram_emu.sv
module nvsram_emu
  import nvsram_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int SUP_W      = 8,
  parameter int LVL_FULL   = 180,
  parameter int LVL_PROT   = 170,
  parameter int LVL_BACKUP = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dIn,
  input  logic [SUP_W-1:0]  supLvl,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              protFlag,
  output logic              backupFlag
);

  strobe_t stb;

  nvsram_ctrl #(
    .SUP_W(SUP_W), .LVL_FULL(LVL_FULL), .LVL_PROT(LVL_PROT), .LVL_BACKUP(LVL_BACKUP)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .supLvl(supLvl),
    .stb(stb), .protFlag(protFlag), .backupFlag(backupFlag)
  );

  nvsram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .dIn(dIn), .stb(stb),
    .dOut(dOut), .dOutEn(dOutEn)
  );

endmodule

// File: tb/test_nvsram_emu.sv
`timescale 1ns/1ps
module test_nvsram_emu;

  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] addr;
  logic        ceN, weN, oeN;
  logic [7:0]  dIn, supLvl;
  logic [7:0]  dOut;
  logic        dOutEn, protFlag, backupFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] model [8192];
  bit         valid [8192];

  always #2 clk = ~clk;

  nvsram_emu i_nvsram_emu (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .weN(weN), .oeN(oeN),
    .dIn(dIn), .supLvl(supLvl), .dOut(dOut), .dOutEn(dOutEn),
    .protFlag(protFlag), .backupFlag(backupFlag)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [12:0] a);
    return model[a];
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // style 0: strobes together, 1: write strobe leads and lags, 2: chip select leads and lags
  task automatic doWrite(input logic [12:0] a, input logic [7:0] d, input int style);
    @(negedge clk);
    addr = a; dIn = d; oeN = 1'b1;
    if (style == 1) begin weN = 1'b0; idle(1); ceN = 1'b0; end
    else if (style == 2) begin ceN = 1'b0; idle(1); weN = 1'b0; end
    else begin ceN = 1'b0; weN = 1'b0; end
    idle(2);
    if (style == 1) begin ceN = 1'b1; idle(1); weN = 1'b1; end
    else if (style == 2) begin weN = 1'b1; idle(1); ceN = 1'b1; end
    else begin ceN = 1'b1; weN = 1'b1; end
    idle(2);
  endtask

  task automatic doRead(input logic [12:0] a, output logic en, output logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    idle(2);
    en = dOutEn; d = dOut;
    ceN = 1'b1; oeN = 1'b1;
    idle(1);
  endtask

  task automatic setSupply(input logic [7:0] s);
    @(negedge clk);
    supLvl = s;
    idle(2);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic       en;
    logic [7:0] d;
    void'($urandom(32'h5eed));
    rstN = 1'b0; addr = '0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; dIn = '0; supLvl = 8'd200;
    idle(3);
    // R1 reset state
    check("R1 dOutEn", dOutEn, 0);
    check("R1 dOut", dOut, 0);
    check("R1 protFlag", protFlag, 1);
    check("R1 backupFlag", backupFlag, 0);
    rstN = 1'b1;
    idle(2);
    check("R5 normal after supply high", protFlag, 0);

    // R3 write styles, R2 read
    doWrite(13'h0000, 8'hA5, 0); model[0] = 8'hA5; valid[0] = 1;
    doWrite(13'h1FFF, 8'h5A, 1); model[13'h1FFF] = 8'h5A; valid[13'h1FFF] = 1;
    doWrite(13'h0ABC, 8'h3C, 2); model[13'h0ABC] = 8'h3C; valid[13'h0ABC] = 1;
    doRead(13'h0000, en, d); check("R2 en", en, 1); check("R3 low addr", d, expRead(0));
    doRead(13'h1FFF, en, d); check("R3 top addr we-first", d, expRead(13'h1FFF));
    doRead(13'h0ABC, en, d); check("R3 ce-first", d, expRead(13'h0ABC));

    // R9 repeated writes to one address
    for (int i = 0; i < 20; i++) begin
      doWrite(13'h0123, 8'(i * 7 + 1), i % 3);
      model[13'h0123] = 8'(i * 7 + 1); valid[13'h0123] = 1;
    end
    doRead(13'h0123, en, d); check("R9 repeated writes", d, expRead(13'h0123));

    // R4 output disabled cases
    @(negedge clk); addr = 13'h0000; ceN = 1'b0; oeN = 1'b0; weN = 1'b0; dIn = 8'h77;
    idle(2);
    check("R4 we low disables", dOutEn, 0);
    check("R4 zero when off", dOut, 0);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1; model[0] = 8'h77;
    idle(2);
    @(negedge clk); addr = 13'h0000; ceN = 1'b0; oeN = 1'b1; weN = 1'b1;
    idle(2); check("R4 oe high disables", dOutEn, 0);
    ceN = 1'b1; oeN = 1'b0; idle(2); check("R4 ce high disables", dOutEn, 0);
    oeN = 1'b1; idle(1);
    doRead(13'h0000, en, d); check("R4 write during gated read", d, expRead(0));

    // random traffic
    for (int i = 0; i < 300; i++) begin
      logic [12:0] a;
      a = 13'($urandom);
      if (($urandom % 3) != 0 && i > 0) begin
        logic [7:0] v;
        v = 8'($urandom);
        doWrite(a, v, int'($urandom % 3));
        model[a] = v; valid[a] = 1;
      end else if (valid[a]) begin
        doRead(a, en, d);
        check("R9 random read", {en, d}, {1'b1, expRead(a)});
      end
    end

    // R7 hysteresis band at both edges
    setSupply(8'd170);
    check("R7 band low edge", protFlag, 0);
    setSupply(8'd180);
    doRead(13'h1FFF, en, d); check("R7 read in band", {en, d}, {1'b1, expRead(13'h1FFF)});

    // R5 lock
    setSupply(8'd169);
    check("R5 lock flag", protFlag, 1);
    check("R5 no backup", backupFlag, 0);
    doWrite(13'h1FFF, 8'hEE, 0);
    doRead(13'h1FFF, en, d); check("R5 read blocked", en, 0);
    setSupply(8'd180);
    check("R6 at full code stays locked", protFlag, 1);
    setSupply(8'd181);
    check("R5 recover", protFlag, 0);
    doRead(13'h1FFF, en, d); check("R5 write ignored", d, expRead(13'h1FFF));

    // R6 retention
    setSupply(8'd119);
    check("R6 backup flag", backupFlag, 1);
    check("R6 prot in backup", protFlag, 1);
    setSupply(8'd120);
    check("R6 backup cleared", backupFlag, 0);
    check("R6 still locked", protFlag, 1);
    setSupply(8'd175);
    check("R6 locked in band", protFlag, 1);
    setSupply(8'd200);
    check("R6 back to normal", protFlag, 0);
    doRead(13'h0ABC, en, d); check("R6 data retained", d, expRead(13'h0ABC));

    // R8 abort of an open overlap
    @(negedge clk); addr = 13'h0ABC; dIn = 8'h99; ceN = 1'b0; weN = 1'b0;
    idle(2);
    supLvl = 8'd150;
    idle(2);
    ceN = 1'b1; weN = 1'b1;
    idle(2);
    setSupply(8'd200);
    doRead(13'h0ABC, en, d); check("R8 aborted write", d, expRead(13'h0ABC));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule